// File: doc/BRIEF.md
# Burst Word Address Sequencer

This block sits in front of a synchronous SRAM and produces the word address for every cycle of a four-beat burst. On a load cycle it registers an external start address, which is also the first word of the burst. On each advance cycle the two lowest address bits step to the next word of the four-word block, and all bits above them stay fixed.

A control input picks one of two stepping orders. The linear order counts the low bits upward modulo four. The interleaved order forms the low bits as the start bits XOR the beat count. The order is sampled together with the start address, so it holds for the whole burst. All inputs are registered on the rising clock edge. When clock-enable is low the sequencer keeps its state and ignores its other inputs. Both outputs come straight from registers.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous active-high reset sets word_addr to 0 and beat_idx to 0, and selects the linear order for any advance that comes before the first load.
- R2: At an edge where clk_en=1 and load_cmd=1, word_addr becomes start_addr and beat_idx becomes 0 in the following cycle. The order given by order_sel (0 = linear, 1 = interleaved) is captured at the same edge.
- R3: At an edge where clk_en=0, word_addr and beat_idx keep their values, whatever load_cmd, order_sel and start_addr are.
- R4: At an edge where clk_en=1 and load_cmd=0, beat_idx increments by one modulo 4.
- R5: In linear order, word_addr[1:0] equals the loaded low bits plus beat_idx, modulo 4. For example, start 2 gives 2, 3, 0, 1.
- R6: In interleaved order, word_addr[1:0] equals the loaded low bits XOR beat_idx. For example, start 1 gives 1, 0, 3, 2, and start 2 gives 2, 3, 0, 1.
- R7: An advance after the fourth beat returns word_addr to the loaded start address, with beat_idx 0, and does not leave the four-word block.
- R8: word_addr bits above bit 1 always equal those of the most recently loaded address. No carry ever passes out of the low two bits.
- R9: order_sel is ignored on advance cycles. Changing it in the middle of a burst does not alter the sequence.
- R10: start_addr is ignored on advance cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | Clock enable. Low freezes the sequencer |
| load_cmd | input | 1 | 1 = load start_addr, 0 = advance the burst |
| order_sel | input | 1 | Burst order captured on load: 0 linear, 1 interleaved |
| start_addr | input | ADDR_W | External burst start address |
| word_addr | output | ADDR_W | Registered word address for the current beat |
| beat_idx | output | 2 | Registered beat number within the burst, 0 to 3 |

## Verification
The assertions expect clk_en, load_cmd, order_sel and start_addr to be known, two-state values at every rising edge once reset has been released. The bench meets this by driving every input on the falling edge from a fixed vector table, and by holding reset high across the first edges. The order checks rebuild the captured order in the checker from load edges alone. They therefore rely on the first burst after reset starting either from a load or from the linear default. The stimulus covers both cases.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;

endpackage

// File: rtl/burst_lowbits_calc.sv
module burst_lowbits_calc
  import burst_seq_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] base_low,
  input  logic [BEAT_W-1:0] beat,
  input  burst_order_e      order,
  output logic [BEAT_W-1:0] low_out
);

  logic [BEAT_W-1:0] lin_low;
  logic [BEAT_W-1:0] ilv_low;

  // Sum truncates to BEAT_W bits, so the carry never reaches the upper address.
  assign lin_low = base_low + beat;
  assign ilv_low = base_low ^ beat;

  always_comb begin
    if (order == ORD_INTERLEAVE) low_out = ilv_low;
    else                         low_out = lin_low;
  end

endmodule

// File: rtl/burst_ctrl_regs.sv
module burst_ctrl_regs
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_en,
  input  logic              load_cmd,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] start_addr,
  output logic [ADDR_W-1:0] base_q,
  output burst_order_e      order_q,
  output logic [BEAT_W-1:0] beat_q,
  output logic [BEAT_W-1:0] beat_next
);

  assign beat_next = load_cmd ? '0 : beat_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      order_q <= ORD_LINEAR;
      beat_q  <= '0;
    end else if (clk_en) begin
      beat_q <= beat_next;
      if (load_cmd) begin
        base_q  <= start_addr;
        order_q <= burst_order_e'(order_sel);
      end
    end
  end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int BURST_LEN = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clk_en,
  input  logic                         load_cmd,
  input  logic                         order_sel,
  input  logic [ADDR_W-1:0]            start_addr,
  output logic [ADDR_W-1:0]            word_addr,
  output logic [$clog2(BURST_LEN)-1:0] beat_idx
);

  localparam int BEAT_W = $clog2(BURST_LEN);

  logic [ADDR_W-1:0] base_q;
  burst_order_e      order_q;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] beat_next;
  logic [BEAT_W-1:0] step_low;
  logic [ADDR_W-1:0] addr_next;

  burst_ctrl_regs #(
    .ADDR_W (ADDR_W),
    .BEAT_W (BEAT_W)
  ) ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .clk_en     (clk_en),
    .load_cmd   (load_cmd),
    .order_sel  (order_sel),
    .start_addr (start_addr),
    .base_q     (base_q),
    .order_q    (order_q),
    .beat_q     (beat_q),
    .beat_next  (beat_next)
  );

  burst_lowbits_calc #(
    .BEAT_W (BEAT_W)
  ) calc_i (
    .base_low (base_q[BEAT_W-1:0]),
    .beat     (beat_next),
    .order    (order_q),
    .low_out  (step_low)
  );

  generate
    if (ADDR_W > BEAT_W) begin : g_upper
      assign addr_next = load_cmd ? start_addr
                                  : {base_q[ADDR_W-1:BEAT_W], step_low};
    end else begin : g_low_only
      assign addr_next = load_cmd ? start_addr : step_low;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      word_addr <= '0;
    end else if (clk_en) begin
      word_addr <= addr_next;
    end
  end

  assign beat_idx = beat_q;

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W    = 17,
  parameter int BURST_LEN = 4
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         clk_en,
  input logic                         load_cmd,
  input logic                         order_sel,
  input logic [ADDR_W-1:0]            start_addr,
  input logic [ADDR_W-1:0]            word_addr,
  input logic [$clog2(BURST_LEN)-1:0] beat_idx
);

  localparam int BW = $clog2(BURST_LEN);

  logic          ord_seen;
  logic [BW-1:0] lin_key;
  logic [BW-1:0] ilv_key;

  assign lin_key = word_addr[BW-1:0] - beat_idx;
  assign ilv_key = word_addr[BW-1:0] ^ beat_idx;

  always_ff @(posedge clk) begin
    if (rst)                      ord_seen <= 1'b0;
    else if (clk_en && load_cmd)  ord_seen <= order_sel;
  end

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (word_addr == '0 && beat_idx == '0));

  a_r2_load_capture: assert property (@(posedge clk) disable iff (rst)
    (clk_en && load_cmd) |=> (word_addr == $past(start_addr) && beat_idx == '0));

  a_r3_freeze: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> ($stable(word_addr) && $stable(beat_idx)));

  a_r4_beat_step: assert property (@(posedge clk) disable iff (rst)
    (clk_en && !load_cmd) |=> (beat_idx == BW'($past(beat_idx) + 1'b1)));

  a_r5_linear_key: assert property (@(posedge clk) disable iff (rst)
    (clk_en && !load_cmd && !ord_seen) |=> $stable(lin_key));

  a_r6_interleave_key: assert property (@(posedge clk) disable iff (rst)
    (clk_en && !load_cmd && ord_seen) |=> $stable(ilv_key));

  a_r8_upper_hold: assert property (@(posedge clk) disable iff (rst)
    (clk_en && !load_cmd) |=> $stable(word_addr[ADDR_W-1:BW]));

endmodule

bind burst_addr_seq burst_addr_seq_chk #(
  .ADDR_W    (ADDR_W),
  .BURST_LEN (BURST_LEN)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .clk_en     (clk_en),
  .load_cmd   (load_cmd),
  .order_sel  (order_sel),
  .start_addr (start_addr),
  .word_addr  (word_addr),
  .beat_idx   (beat_idx)
);

// File: tb/burst_addr_seq_tb_top.sv
module burst_addr_seq_tb_top;

  localparam int AW = 17;
  localparam int NV = 17;

  typedef struct packed {
    logic          en;
    logic          ld;
    logic          ord;
    logic [AW-1:0] a;
    logic [AW-1:0] e;
    logic [1:0]    b;
    logic [3:0]    req;
  } vec_t;

  // Encoding: ld=1 load / 0 advance, ord=0 linear / 1 interleaved.
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 1'b0, 17'h12346, 17'h12346, 2'd0, 4'd2},  // R2 load, linear
    '{1'b1, 1'b0, 1'b0, 17'h00000, 17'h12347, 2'd1, 4'd5},  // R5
    '{1'b1, 1'b0, 1'b0, 17'h00000, 17'h12344, 2'd2, 4'd5},  // R5 wrap of low bits
    '{1'b1, 1'b0, 1'b0, 17'h1FFFF, 17'h12345, 2'd3, 4'd10}, // R10 start ignored
    '{1'b1, 1'b0, 1'b0, 17'h00000, 17'h12346, 2'd0, 4'd7},  // R7 back to start
    '{1'b0, 1'b1, 1'b1, 17'h00003, 17'h12346, 2'd0, 4'd3},  // R3 frozen
    '{1'b1, 1'b1, 1'b1, 17'h0ABC1, 17'h0ABC1, 2'd0, 4'd2},  // R2 load, interleaved
    '{1'b1, 1'b0, 1'b0, 17'h00000, 17'h0ABC0, 2'd1, 4'd9},  // R9 order pin ignored
    '{1'b1, 1'b0, 1'b0, 17'h00000, 17'h0ABC3, 2'd2, 4'd6},  // R6
    '{1'b1, 1'b0, 1'b1, 17'h00000, 17'h0ABC2, 2'd3, 4'd6},  // R6
    '{1'b1, 1'b0, 1'b1, 17'h00000, 17'h0ABC1, 2'd0, 4'd7},  // R7
    '{1'b1, 1'b1, 1'b1, 17'h00002, 17'h00002, 2'd0, 4'd2},  // R2
    '{1'b1, 1'b0, 1'b1, 17'h00000, 17'h00003, 2'd1, 4'd6},  // R6 start 2
    '{1'b1, 1'b0, 1'b1, 17'h00000, 17'h00000, 2'd2, 4'd6},  // R6
    '{1'b1, 1'b0, 1'b1, 17'h00000, 17'h00001, 2'd3, 4'd4},  // R4 beat count
    '{1'b1, 1'b1, 1'b0, 17'h1FFFF, 17'h1FFFF, 2'd0, 4'd2},  // R2
    '{1'b1, 1'b0, 1'b0, 17'h00000, 17'h1FFFC, 2'd1, 4'd8}   // R8 no carry upward
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          clk_en = 1'b0;
  logic          load_cmd = 1'b0;
  logic          order_sel = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [AW-1:0] word_addr;
  logic [1:0]    beat_idx;

  int  n_run  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #10 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .BURST_LEN(4)) dut_i (
    .clk        (clk),
    .rst        (rst),
    .clk_en     (clk_en),
    .load_cmd   (load_cmd),
    .order_sel  (order_sel),
    .start_addr (start_addr),
    .word_addr  (word_addr),
    .beat_idx   (beat_idx)
  );

  task automatic check(input int req, input logic [AW-1:0] ea, input logic [1:0] eb);
    n_run++;
    if (word_addr !== ea || beat_idx !== eb) begin
      n_fail++;
      $display("FAIL R%0d: addr=%h beat=%0d, expected addr=%h beat=%0d",
               req, word_addr, beat_idx, ea, eb);
    end
  endtask

  task automatic step(input logic en, input logic ld, input logic ord,
                      input logic [AW-1:0] a);
    clk_en = en; load_cmd = ld; order_sel = ord; start_addr = a;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(1, '0, 2'd0);  // R1 reset state
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      step(VECS[i].en, VECS[i].ld, VECS[i].ord, VECS[i].a);
      check(int'(VECS[i].req), VECS[i].e, VECS[i].b);
    end
    // R1: reset in mid-burst, then advance uses linear default from base 0
    step(1'b1, 1'b0, 1'b0, '0);
    rst = 1'b1;
    step(1'b1, 1'b0, 1'b1, 17'h05555);
    check(1, '0, 2'd0);
    rst = 1'b0;
    step(1'b1, 1'b0, 1'b1, 17'h05555);
    check(1, 17'h00001, 2'd1);
    // R3: frozen under a load request with a different order
    step(1'b0, 1'b1, 1'b1, 17'h1AAAA);
    check(3, 17'h00001, 2'd1);
    // R7: full four advances from a linear start of 3 return to it
    step(1'b1, 1'b1, 1'b0, 17'h08883);
    for (int k = 0; k < 4; k++) step(1'b1, 1'b0, 1'b0, '0);
    check(7, 17'h08883, 2'd0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule